// File: doc/BRIEF.md
# Descriptor-Driven Interrupt Transfer Engine

This block services an enabled peripheral interrupt request by moving one data item between an I/O register and a memory buffer, so that no software handler runs for it. Each of sixteen channels owns an 8-byte descriptor in a fixed RAM window. The descriptor gives the transfer options, the item count, the I/O register address and the buffer address. The engine reads the descriptor, moves one byte or one little-endian word, and writes the updated count and addresses back into the descriptor. The CPU is held stalled for the whole of this sequence.

When the sequence ends, the engine presents a two-bit termination code for the channel, together with the channel number. A CPU interrupt is raised only when the code calls for one: the count has run out, or the peripheral asked for the transfer to stop. The memory port is byte-wide. Read data is combinational and is valid in the same cycle as the address.

Top module: `xse_engine`

## Requirements
- R1: While reset is applied, and after it is released with no request, `cpu_hold`, `mem_re`, `mem_we`, `term_valid`, `cpu_irq` and `req_ack` are all 0.
- R2: A request is accepted (`req_ack` high for that cycle) only when `req_enable` is 1. A request with `req_enable` at 0 is ignored: there is no hold, no bus access and no descriptor change.
- R3: The descriptor for channel n is read at byte addresses 0x0100+8n up to 0x0107+8n, in ascending order. Byte 0 is the mode, bytes 2–3 are the count, bytes 4–5 are the I/O address and bytes 6–7 are the buffer address, all little-endian. The mode byte is never rewritten, and `term_chan` reports n.
- R4: Mode bit 0 sets the direction: 0 moves data from the I/O address to the buffer, and 1 moves it from the buffer to the I/O address. Mode bit 1 sets the item size: 1 means a word (two bytes, low byte at the lower address), and 0 means a single byte, so the byte above is left untouched.
- R5: The I/O address written back is advanced by the item size (1 or 2) when mode bit 2 is set, and is unchanged otherwise.
- R6: The buffer address written back is advanced by the item size when mode bit 3 is set, and is unchanged otherwise.
- R7: The count written back is the old count minus one, modulo 2^16 (0 becomes 0xFFFF).
- R8: When a transfer ends normally, `term_status` is 01 and `cpu_irq` pulses with `term_valid` if the new count is zero. Otherwise `term_status` is 00 and there is no interrupt. Code 10 never appears.
- R9: If `periph_stop` is 1 when a request is accepted, no data and no descriptor bytes are touched. `term_valid` comes in the next cycle with `term_status` = 11 and `cpu_irq` = 1.
- R10: `cpu_hold` rises in the cycle after acceptance and stays high through the `term_valid` cycle, which is cycle 17 for a byte item and cycle 19 for a word item (cycle 1 in the stopped case). It is low in the following cycle. Every bus access happens while `cpu_hold` is high.
- R11: A request raised while the engine is busy gets no `req_ack` until the engine is idle again. It is then accepted in the first idle cycle and serviced in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Peripheral service request, held until acknowledged |
| req_enable | input | 1 | Service-enable bit from the requester's control register |
| req_chan | input | CHAN_W | Descriptor channel from the requester's control register |
| periph_stop | input | 1 | Peripheral asks for the transfer to end, sampled at acceptance |
| req_ack | output | 1 | Request accepted in this cycle |
| cpu_hold | output | 1 | Stall the CPU while the engine is active |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as the address |
| term_valid | output | 1 | Termination code valid in this cycle |
| term_status | output | 2 | Termination code: 00 more, 01 count zero, 11 stopped |
| term_chan | output | CHAN_W | Channel the code belongs to |
| cpu_irq | output | 1 | CPU interrupt pulse |

## Verification
`req_ack` is combinational, so the bench samples it one nanosecond after driving the request. Cycles are counted from the falling edge that follows the acceptance edge, which is counted as cycle 1. `term_valid`, `term_status` and `cpu_irq` are due in cycle 17 for byte items, cycle 19 for word items and cycle 1 for a stopped request. The bench compares the counted cycle to these numbers exactly and checks that `cpu_hold` was high in every one of those cycles and low in the next. The last descriptor write lands on the rising edge just before the `term_valid` cycle, so the memory contents are read only after `term_valid` has been seen.

// File: rtl/xse_pkg.sv
package xse_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DESC = 3'd1,
    ST_SRC  = 3'd2,
    ST_DST  = 3'd3,
    ST_WBK  = 3'd4,
    ST_FIN  = 3'd5
  } xse_state_e;

  // mode byte bit positions
  localparam int unsigned MB_DIR    = 0;
  localparam int unsigned MB_WORD   = 1;
  localparam int unsigned MB_IOINC  = 2;
  localparam int unsigned MB_BUFINC = 3;
  localparam int unsigned MODE_W    = 4;

  // termination codes
  localparam logic [1:0] TS_MORE = 2'b00;
  localparam logic [1:0] TS_ZERO = 2'b01;
  localparam logic [1:0] TS_STOP = 2'b11;

  localparam int unsigned DESC_BYTES = 8;
  localparam int unsigned IDX_W      = $clog2(DESC_BYTES);
  localparam int unsigned WB_FIRST   = 2;   // first descriptor byte written back
endpackage

// File: rtl/xse_rst_sync.sv
module xse_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_sync_n = s1_q;
endmodule

// File: rtl/xse_fsm.sv
module xse_fsm
  import xse_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             word_i,
  output xse_state_e       state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             stopped_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_BYTES - 1);
  localparam logic [IDX_W-1:0] WB_IDX   = IDX_W'(WB_FIRST);
  localparam logic [IDX_W-1:0] ONE      = IDX_W'(1);

  xse_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             stop_q, stop_d;
  logic             last_item;

  assign last_item = word_i ? (idx_q == ONE) : (idx_q == '0);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    stop_d  = stop_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          idx_d   = '0;
          stop_d  = stop_i;
          state_d = stop_i ? ST_FIN : ST_DESC;
        end
      end
      ST_DESC: begin
        idx_d = idx_q + ONE;
        if (idx_q == LAST_IDX) begin
          idx_d   = '0;
          state_d = ST_SRC;
        end
      end
      ST_SRC: begin
        idx_d = idx_q + ONE;
        if (last_item) begin
          idx_d   = '0;
          state_d = ST_DST;
        end
      end
      ST_DST: begin
        idx_d = idx_q + ONE;
        if (last_item) begin
          idx_d   = WB_IDX;
          state_d = ST_WBK;
        end
      end
      ST_WBK: begin
        idx_d = idx_q + ONE;
        if (idx_q == LAST_IDX) begin
          idx_d   = '0;
          state_d = ST_FIN;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      stop_q  <= stop_d;
    end
  end

  assign state_o   = state_q;
  assign idx_o     = idx_q;
  assign stopped_o = stop_q;
endmodule

// File: rtl/xse_desc_regs.sv
module xse_desc_regs
  import xse_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_en_i,
  input  logic              item_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        rdata_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [15:0]       item_o,
  output logic [15:0]       count_next_o,
  output logic [ADDR_W-1:0] io_next_o,
  output logic [ADDR_W-1:0] buf_next_o
);
  logic [MODE_W-1:0] mode_q;
  logic [15:0]       count_q;
  logic [ADDR_W-1:0] io_q, buf_q;
  logic [15:0]       item_q;
  logic [ADDR_W-1:0] step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      count_q <= '0;
      io_q    <= '0;
      buf_q   <= '0;
    end else if (desc_en_i) begin
      unique case (idx_i)
        3'd0:    mode_q        <= rdata_i[MODE_W-1:0];
        3'd2:    count_q[7:0]  <= rdata_i;
        3'd3:    count_q[15:8] <= rdata_i;
        3'd4:    io_q[7:0]     <= rdata_i;
        3'd5:    io_q[15:8]    <= rdata_i;
        3'd6:    buf_q[7:0]    <= rdata_i;
        3'd7:    buf_q[15:8]   <= rdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      item_q <= '0;
    end else if (item_en_i) begin
      if (idx_i[0]) item_q[15:8] <= rdata_i;
      else          item_q[7:0]  <= rdata_i;
    end
  end

  assign step         = mode_q[MB_WORD] ? ADDR_W'(2) : ADDR_W'(1);
  assign count_next_o = count_q - 16'd1;
  assign io_next_o    = mode_q[MB_IOINC]  ? io_q + step  : io_q;
  assign buf_next_o   = mode_q[MB_BUFINC] ? buf_q + step : buf_q;

  assign mode_o     = mode_q;
  assign io_addr_o  = io_q;
  assign buf_addr_o = buf_q;
  assign item_o     = item_q;
endmodule

// File: rtl/xse_bus_drv.sv
module xse_bus_drv
  import xse_pkg::*;
#(
  parameter int unsigned      ADDR_W    = 16,
  parameter int unsigned      CHAN_W    = 4,
  parameter logic [ADDR_W-1:0] DESC_BASE = 16'h0100
) (
  input  xse_state_e        state_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [ADDR_W-1:0] buf_addr_i,
  input  logic [15:0]       item_i,
  input  logic [15:0]       count_next_i,
  input  logic [ADDR_W-1:0] io_next_i,
  input  logic [ADDR_W-1:0] buf_next_i,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o
);
  logic [ADDR_W-1:0] desc_base, src_base, dst_base, off;
  logic [7:0]        wb_byte;

  assign desc_base = DESC_BASE + ADDR_W'({chan_i, {IDX_W{1'b0}}});
  assign src_base  = mode_i[MB_DIR] ? buf_addr_i : io_addr_i;
  assign dst_base  = mode_i[MB_DIR] ? io_addr_i  : buf_addr_i;
  assign off       = ADDR_W'(idx_i);

  always_comb begin
    unique case (idx_i)
      3'd2:    wb_byte = count_next_i[7:0];
      3'd3:    wb_byte = count_next_i[15:8];
      3'd4:    wb_byte = io_next_i[7:0];
      3'd5:    wb_byte = io_next_i[15:8];
      3'd6:    wb_byte = buf_next_i[7:0];
      3'd7:    wb_byte = buf_next_i[15:8];
      default: wb_byte = 8'h00;
    endcase
  end

  always_comb begin
    mem_re_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = 8'h00;
    unique case (state_i)
      ST_DESC: begin
        mem_re_o   = 1'b1;
        mem_addr_o = desc_base + off;
      end
      ST_SRC: begin
        mem_re_o   = 1'b1;
        mem_addr_o = src_base + off;
      end
      ST_DST: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = dst_base + off;
        mem_wdata_o = idx_i[0] ? item_i[15:8] : item_i[7:0];
      end
      ST_WBK: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_base + off;
        mem_wdata_o = wb_byte;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xse_engine.sv
module xse_engine
  import xse_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       CHAN_W    = 4,
  parameter logic [ADDR_W-1:0] DESC_BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_enable,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic              periph_stop,
  output logic              req_ack,
  output logic              cpu_hold,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              term_valid,
  output logic [1:0]        term_status,
  output logic [CHAN_W-1:0] term_chan,
  output logic              cpu_irq
);
  logic              rst_sync_n;
  xse_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic              stopped;
  logic              accept;
  logic [CHAN_W-1:0] chan_q;
  logic [MODE_W-1:0] mode;
  logic [ADDR_W-1:0] io_addr, buf_addr, io_next, buf_next;
  logic [15:0]       item, count_next;

  xse_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign accept = rst_sync_n && (state == ST_IDLE) && req_valid && req_enable;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  chan_q <= '0;
    else if (accept)  chan_q <= req_chan;
  end

  xse_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (accept),
    .stop_i    (periph_stop),
    .word_i    (mode[MB_WORD]),
    .state_o   (state),
    .idx_o     (idx),
    .stopped_o (stopped)
  );

  xse_desc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .desc_en_i    (state == ST_DESC),
    .item_en_i    (state == ST_SRC),
    .idx_i        (idx),
    .rdata_i      (mem_rdata),
    .mode_o       (mode),
    .io_addr_o    (io_addr),
    .buf_addr_o   (buf_addr),
    .item_o       (item),
    .count_next_o (count_next),
    .io_next_o    (io_next),
    .buf_next_o   (buf_next)
  );

  xse_bus_drv #(
    .ADDR_W    (ADDR_W),
    .CHAN_W    (CHAN_W),
    .DESC_BASE (DESC_BASE)
  ) u_bus (
    .state_i      (state),
    .idx_i        (idx),
    .chan_i       (chan_q),
    .mode_i       (mode),
    .io_addr_i    (io_addr),
    .buf_addr_i   (buf_addr),
    .item_i       (item),
    .count_next_i (count_next),
    .io_next_i    (io_next),
    .buf_next_i   (buf_next),
    .mem_re_o     (mem_re),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata)
  );

  assign req_ack     = accept;
  assign cpu_hold    = (state != ST_IDLE);
  assign term_valid  = (state == ST_FIN);
  assign term_status = stopped ? TS_STOP : ((count_next == 16'd0) ? TS_ZERO : TS_MORE);
  assign term_chan   = chan_q;
  assign cpu_irq     = term_valid && (term_status != TS_MORE);
endmodule

// File: rtl/xse_checker.sv
module xse_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_enable,
  input logic       periph_stop,
  input logic       req_ack,
  input logic       cpu_hold,
  input logic       mem_re,
  input logic       mem_we,
  input logic       term_valid,
  input logic [1:0] term_status,
  input logic       cpu_irq
);
  p_no_ack_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_enable |-> !req_ack);

  p_bus_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  p_irq_with_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> term_valid);

  p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    term_valid |-> (term_status != 2'b10));

  p_stop_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack && periph_stop) |=> (term_valid && term_status == 2'b11 && cpu_irq));

  p_ack_starts_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> cpu_hold);

  p_release_after_term_r10: assert property (@(posedge clk) disable iff (!rst_n)
    term_valid |=> (!cpu_hold && !term_valid));

  p_bus_needs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we) |-> cpu_hold);

  p_ack_only_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> !cpu_hold);
endmodule

bind xse_engine xse_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_enable  (req_enable),
  .periph_stop (periph_stop),
  .req_ack     (req_ack),
  .cpu_hold    (cpu_hold),
  .mem_re      (mem_re),
  .mem_we      (mem_we),
  .term_valid  (term_valid),
  .term_status (term_status),
  .cpu_irq     (cpu_irq)
);

// File: tb/tb_xse_engine.sv
`timescale 1ns/1ps
module tb_xse_engine;
  localparam int NVEC = 6;
  // {chan[4], mode[4], count[16], io[16], buf[16], data[16]}
  localparam logic [71:0] VEC [0:NVEC-1] = '{
    72'h00_0005_0210_0300_00A5,
    72'h3C_0002_0220_0310_003C,
    72'h7B_0001_0230_0320_BEEF,
    72'hF7_0100_0240_0330_1234,
    72'h92_0000_0250_0340_CAFE,
    72'hCE_0001_0260_0350_5A69
  };

  logic        clk, rst_n;
  logic        req_valid, req_enable, periph_stop;
  logic [3:0]  req_chan;
  logic        req_ack, cpu_hold, mem_re, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        term_valid, cpu_irq;
  logic [1:0]  term_status;
  logic [3:0]  term_chan;

  logic [7:0]  mem [0:1023];
  int          n_tests, n_fail;

  xse_engine dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_enable(req_enable),
    .req_chan(req_chan), .periph_stop(periph_stop), .req_ack(req_ack),
    .cpu_hold(cpu_hold), .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .term_valid(term_valid),
    .term_status(term_status), .term_chan(term_chan), .cpu_irq(cpu_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd16(input logic [15:0] a);
    return {mem[a[9:0] + 10'd1], mem[a[9:0]]};
  endfunction

  task automatic put_desc(input logic [3:0] ch, input logic [7:0] md,
                          input logic [15:0] cnt, input logic [15:0] io,
                          input logic [15:0] bf);
    int b;
    b = 256 + 8 * ch;
    mem[b]   = md;         mem[b+1] = 8'h00;
    mem[b+2] = cnt[7:0];   mem[b+3] = cnt[15:8];
    mem[b+4] = io[7:0];    mem[b+5] = io[15:8];
    mem[b+6] = bf[7:0];    mem[b+7] = bf[15:8];
  endtask

  // issue one request and wait for its termination; cycle 1 = first cycle after acceptance
  task automatic do_xfer(input logic [3:0] ch, input bit stop, output int cyc,
                         output logic [1:0] st, output logic irq, output logic [3:0] tch,
                         output bit hold_ok);
    @(negedge clk);
    req_valid = 1'b1; req_enable = 1'b1; req_chan = ch; periph_stop = stop;
    #1;
    chk(req_ack == 1'b1, "R2", "ack on enabled request", int'(req_ack), 1);
    @(negedge clk);
    req_valid = 1'b0; periph_stop = 1'b0;
    cyc = 1; hold_ok = 1'b1;
    while (!term_valid && cyc < 64) begin
      if (!cpu_hold) hold_ok = 1'b0;
      @(negedge clk);
      cyc++;
    end
    if (!cpu_hold) hold_ok = 1'b0;
    st = term_status; irq = cpu_irq; tch = term_chan;
    @(negedge clk);
    chk(cpu_hold == 1'b0, "R10", "hold released after term", int'(cpu_hold), 0);
  endtask

  initial begin
    int unsigned wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", wd, 20000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int          cyc;
    logic [1:0]  st;
    logic        irq;
    logic [3:0]  tch;
    bit          hold_ok;
    logic [71:0] e;
    logic [3:0]  ch, md;
    logic [15:0] cnt, io, bf, dat, src, dst, step, exp_cnt;
    logic [1:0]  exp_st;

    n_tests = 0; n_fail = 0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    rst_n = 1'b0; req_valid = 1'b0; req_enable = 1'b0; req_chan = '0; periph_stop = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet while in reset
    chk(cpu_hold == 0 && mem_re == 0 && mem_we == 0, "R1", "bus/hold in reset",
        int'({cpu_hold, mem_re, mem_we}), 0);
    chk(term_valid == 0 && cpu_irq == 0 && req_ack == 0, "R1", "term/irq in reset",
        int'({term_valid, cpu_irq, req_ack}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cpu_hold == 0 && mem_re == 0 && mem_we == 0 && term_valid == 0 && cpu_irq == 0,
        "R1", "idle after reset", int'({cpu_hold, mem_re, mem_we, term_valid, cpu_irq}), 0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      e   = VEC[v];
      ch  = e[71:68]; md = e[67:64]; cnt = e[63:48];
      io  = e[47:32]; bf = e[31:16]; dat = e[15:0];
      step = md[1] ? 16'd2 : 16'd1;
      src  = md[0] ? bf : io;
      dst  = md[0] ? io : bf;
      put_desc(ch, {4'h0, md}, cnt, io, bf);
      mem[src[9:0]] = dat[7:0]; mem[src[9:0] + 10'd1] = dat[15:8];
      mem[dst[9:0]] = 8'hEE;    mem[dst[9:0] + 10'd1] = 8'hEE;
      do_xfer(ch, 1'b0, cyc, st, irq, tch, hold_ok);
      exp_cnt = cnt - 16'd1;
      exp_st  = (exp_cnt == 16'd0) ? 2'b01 : 2'b00;
      chk(cyc == 15 + 2 * int'(step), "R10", "term cycle", cyc, 15 + 2 * int'(step));
      chk(hold_ok, "R10", "hold through transfer", int'(hold_ok), 1);
      chk(st == exp_st, "R8", "status code", int'(st), int'(exp_st));
      chk(irq == (exp_st != 2'b00), "R8", "irq", int'(irq), int'(exp_st != 2'b00));
      chk(tch == ch, "R3", "term channel", int'(tch), int'(ch));
      chk(mem[dst[9:0]] == dat[7:0], "R4", "dest low byte", int'(mem[dst[9:0]]), int'(dat[7:0]));
      if (md[1])
        chk(mem[dst[9:0] + 10'd1] == dat[15:8], "R4", "dest high byte",
            int'(mem[dst[9:0] + 10'd1]), int'(dat[15:8]));
      else
        chk(mem[dst[9:0] + 10'd1] == 8'hEE, "R4", "byte above untouched",
            int'(mem[dst[9:0] + 10'd1]), 'hEE);
      chk(rd16(16'h0102 + 16'(8 * ch)) == exp_cnt, "R7", "count writeback",
          int'(rd16(16'h0102 + 16'(8 * ch))), int'(exp_cnt));
      chk(rd16(16'h0104 + 16'(8 * ch)) == (md[2] ? io + step : io), "R5", "io writeback",
          int'(rd16(16'h0104 + 16'(8 * ch))), int'(md[2] ? io + step : io));
      chk(rd16(16'h0106 + 16'(8 * ch)) == (md[3] ? bf + step : bf), "R6", "buf writeback",
          int'(rd16(16'h0106 + 16'(8 * ch))), int'(md[3] ? bf + step : bf));
      chk(mem[256 + 8 * ch] == {4'h0, md}, "R3", "mode byte kept",
          int'(mem[256 + 8 * ch]), int'(md));
    end

    // R2: request with enable low is ignored
    put_desc(4'd4, 8'h00, 16'd9, 16'h0280, 16'h0370);
    @(negedge clk);
    req_valid = 1'b1; req_enable = 1'b0; req_chan = 4'd4;
    for (int k = 0; k < 6; k++) begin
      #1;
      chk(req_ack == 0 && cpu_hold == 0 && mem_re == 0 && mem_we == 0, "R2",
          "disabled request ignored", int'({req_ack, cpu_hold, mem_re, mem_we}), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(rd16(16'h0122) == 16'd9, "R2", "count untouched when disabled", int'(rd16(16'h0122)), 9);

    // R9: peripheral stop at acceptance
    put_desc(4'd5, 8'h0C, 16'd4, 16'h0290, 16'h0380);
    mem[10'h290] = 8'h77; mem[10'h380] = 8'hEE;
    do_xfer(4'd5, 1'b1, cyc, st, irq, tch, hold_ok);
    chk(cyc == 1, "R9", "stop term cycle", cyc, 1);
    chk(st == 2'b11, "R9", "stop status", int'(st), 3);
    chk(irq == 1'b1, "R9", "stop irq", int'(irq), 1);
    chk(mem[10'h380] == 8'hEE, "R9", "no data moved", int'(mem[10'h380]), 'hEE);
    chk(rd16(16'h012A) == 16'd4 && rd16(16'h012C) == 16'h0290, "R9", "descriptor untouched",
        int'(rd16(16'h012A)), 4);

    // R11: request raised while busy waits for idle
    put_desc(4'd0, 8'h00, 16'd3, 16'h0210, 16'h0300);
    put_desc(4'd1, 8'h00, 16'd7, 16'h0211, 16'h0301);
    @(negedge clk);
    req_valid = 1'b1; req_enable = 1'b1; req_chan = 4'd0;
    @(negedge clk);
    req_chan = 4'd1;   // second request held high while busy
    cyc = 1;
    while (!term_valid && cyc < 64) begin
      chk(req_ack == 1'b0, "R11", "no ack while busy", int'(req_ack), 0);
      @(negedge clk);
      cyc++;
    end
    chk(req_ack == 1'b0, "R11", "no ack in term cycle", int'(req_ack), 0);
    @(negedge clk);
    #1;
    chk(req_ack == 1'b1 && cpu_hold == 1'b0, "R11", "ack in first idle cycle",
        int'({req_ack, cpu_hold}), 2);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!term_valid && cyc < 64) begin
      @(negedge clk);
      cyc++;
    end
    chk(term_chan == 4'd1 && cyc == 17, "R11", "pending request serviced",
        int'({term_chan, 8'(cyc)}), int'({4'd1, 8'd17}));
    @(negedge clk);
    chk(rd16(16'h0102) == 16'd2 && rd16(16'h010A) == 16'd6, "R11", "both counts decremented",
        int'({rd16(16'h0102), rd16(16'h010A)}), int'({16'd2, 16'd6}));

    // R1: reset mid-transfer returns to quiet state
    put_desc(4'd2, 8'h02, 16'd5, 16'h0220, 16'h0310);
    @(negedge clk);
    req_valid = 1'b1; req_enable = 1'b1; req_chan = 4'd2;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(cpu_hold == 0 && mem_re == 0 && mem_we == 0 && term_valid == 0, "R1",
        "reset aborts transfer", int'({cpu_hold, mem_re, mem_we, term_valid}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule